// File: doc/BRIEF.md
# Circular Search-Window Address Generator

This block turns a motion vector into the read addresses for one block-matching pass over a search-window buffer. The buffer is spread across eight byte-wide RAMs. Horizontally adjacent pixels sit in adjacent RAMs, so pixel column `c` is always held in RAM `c mod 8`. Each RAM has two read ports, which lets one buffer line supply all 16 pixels of a block row in a single cycle.

Horizontally, the buffer is run as a ring. The window's left edge sits at a programmable start offset, given in units of 16 columns. The vector is first placed relative to a fixed origin inside the window, which gives a logical coordinate. The offset is then added to the column only, modulo the buffer width, which gives the physical coordinate. The line coordinate is never remapped.

A 16-pixel row starting at physical column `px` covers three 8-column groups. The block forms one word address per group and tells each of the 16 lanes which of the three it uses. Where the row runs past the right edge of the buffer, the group index wraps back to column 0. A start pulse captures the inputs. The block then issues 16 rows on consecutive cycles, moving down one buffer line per row, and ends with a done pulse.

Top module: `sw_addr_gen`

## Requirements
- R1: After reset, `row_valid` and `row_done` are 0 and every word address output is 0.
- R2: A `start` sampled while idle captures the inputs. From the next cycle, `row_valid` is 1 for exactly 16 consecutive cycles, and `row_idx` counts 0 to 15.
- R3: `row_done` is a single-cycle pulse. It occurs in the cycle right after row 15, when `row_valid` has already returned to 0.
- R4: A `start` sampled while `row_valid` is 1 has no effect. This includes a `start` during the last row: the burst and its addresses continue unchanged, and no new burst begins.
- R5: The physical column is `px = (ORG_X + vec_x + 16*win_ofs) mod 64`, with `vec_x` a two's-complement value. The line for row `r` is `(ORG_Y + vec_y + r) mod 64`, with no offset applied.
- R6: A word address is `line*8 + group`, where `group = column div 8`. Field `word_addr[j*9 +: 9]` (j = 0, 1, 2) carries group `(px div 8 + j) mod 8`. A group past the right edge wraps to group 0.
- R7: From one row to the next, every word address increases by 8 (one buffer line), modulo 512.
- R8: `lane_sel[2k +: 2]` gives lane k's area as `((px mod 8) + k) div 8`, coded 0, 1 or 2, naming the word address that lane reads.
- R9: Lane k (k < 8) is served by port A of RAM `(px+k) mod 8`, and lane k+8 by port B of the same RAM. Each such port carries `line*8 + ((px+k) mod 64) div 8` for its lane's column. Port fields are `ram_addr_a[m*9 +: 9]` and `ram_addr_b[m*9 +: 9]`.
- R10: Changes to `vec_x`, `vec_y` or `win_ofs` after the capturing cycle do not affect the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a 16-row burst when idle |
| vec_x | input | 6 | Horizontal vector, signed |
| vec_y | input | 6 | Vertical vector, signed |
| win_ofs | input | 2 | Window start offset in units of 16 columns |
| row_valid | output | 1 | Addresses for a row are valid |
| row_idx | output | 4 | Row number within the burst |
| row_done | output | 1 | One-cycle pulse after the last row |
| word_addr | output | 27 | Three word addresses for the row, one per 8-column area |
| ram_addr_a | output | 72 | Port A address of each of the 8 RAMs |
| ram_addr_b | output | 72 | Port B address of each of the 8 RAMs |
| lane_sel | output | 32 | 2-bit area code for each of the 16 lanes |

## Verification
Every horizontal vector value is swept at each of the four offsets. Every starting phase within a RAM group therefore appears, along with every spot at which a row crosses the right edge of the buffer. Each sweep runs at two vertical positions: one at the top line, and one whose 16 rows run past line 63. This separates column wraparound from line wraparound. A separate sweep covers every vertical value at a fixed column, to confirm that the offset never reaches the line. Further bursts carry extra start pulses in the middle row and in the final row. In every burst, the inputs are altered once capture is done, which shows whether the captured values are held.

// File: rtl/swag_pkg.sv
package swag_pkg;
  // Area codes name which of the three row word addresses a lane reads.
  typedef enum logic [1:0] {
    AREA_FIRST  = 2'd0,
    AREA_SECOND = 2'd1,
    AREA_THIRD  = 2'd2
  } area_e;

  localparam int AREA_N = 3;
endpackage

// File: rtl/swag_coord.sv
module swag_coord #(
  parameter int VEC_W    = 6,
  parameter int COL_W    = 6,
  parameter int ROW_W    = 6,
  parameter int OFS_W    = 2,
  parameter int OFS_STEP = 16,
  parameter int ORG_X    = 24,
  parameter int ORG_Y    = 24
) (
  input  logic signed [VEC_W-1:0] vec_x,
  input  logic signed [VEC_W-1:0] vec_y,
  input  logic [OFS_W-1:0]        win_ofs,
  output logic [COL_W-1:0]        phys_x,
  output logic [ROW_W-1:0]        phys_y
);
  // Origin plus vector, reduced to the ring width (power of two).
  function automatic logic [COL_W-1:0] place_col(input logic signed [VEC_W-1:0] v);
    int s;
    s = ORG_X + int'(v);
    return s[COL_W-1:0];
  endfunction

  function automatic logic [ROW_W-1:0] place_row(input logic signed [VEC_W-1:0] v);
    int s;
    s = ORG_Y + int'(v);
    return s[ROW_W-1:0];
  endfunction

  // The window start is added to the column only.
  function automatic logic [COL_W-1:0] ring_col(input logic [COL_W-1:0] lx,
                                                input logic [OFS_W-1:0] ofs);
    logic [COL_W-1:0] shift;
    shift = COL_W'(OFS_STEP) * COL_W'(ofs);
    return lx + shift;
  endfunction

  logic [COL_W-1:0] log_x;

  assign log_x  = place_col(vec_x);
  assign phys_x = ring_col(log_x, win_ofs);
  assign phys_y = place_row(vec_y);
endmodule

// File: rtl/swag_row_seq.sv
module swag_row_seq #(
  parameter int ROWS       = 16,
  parameter int LINE_WORDS = 8,
  parameter int COL_W      = 6,
  parameter int ROW_W      = 6,
  parameter int PH_W       = 3,
  parameter int GRP_W      = 3,
  parameter int ADDR_W     = 9,
  parameter int RCNT_W     = 4,
  parameter int AREA_N     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [COL_W-1:0]         phys_x,
  input  logic [ROW_W-1:0]         phys_y,
  output logic                     row_valid,
  output logic [RCNT_W-1:0]        row_idx,
  output logic                     row_done,
  output logic [AREA_N*ADDR_W-1:0] word_addr,
  output logic [PH_W-1:0]          phase,
  output logic                     launch,
  output logic                     last_row
);
  function automatic logic [ADDR_W-1:0] word_of(input logic [ROW_W-1:0] line,
                                                input logic [GRP_W-1:0] grp);
    return {line, grp};
  endfunction

  logic [AREA_N*ADDR_W-1:0] first_addr;

  for (genvar j = 0; j < AREA_N; j++) begin : g_area
    assign first_addr[j*ADDR_W +: ADDR_W] =
      word_of(phys_y, phys_x[COL_W-1:PH_W] + GRP_W'(j));
  end

  assign launch   = start && !row_valid;
  assign last_row = row_valid && (row_idx == RCNT_W'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_valid <= 1'b0;
      row_idx   <= '0;
      row_done  <= 1'b0;
      word_addr <= '0;
      phase     <= '0;
    end else begin
      row_done <= 1'b0;
      if (launch) begin
        row_valid <= 1'b1;
        row_idx   <= '0;
        word_addr <= first_addr;
        phase     <= phys_x[PH_W-1:0];
      end else if (row_valid) begin
        if (last_row) begin
          row_valid <= 1'b0;
          row_done  <= 1'b1;
        end else begin
          row_idx <= row_idx + RCNT_W'(1);
          for (int j = 0; j < AREA_N; j++) begin
            word_addr[j*ADDR_W +: ADDR_W] <=
              word_addr[j*ADDR_W +: ADDR_W] + ADDR_W'(LINE_WORDS);
          end
        end
      end
    end
  end
endmodule

// File: rtl/swag_lane_map.sv
module swag_lane_map #(
  parameter int LANES  = 16,
  parameter int NRAM   = 8,
  parameter int PH_W   = 3,
  parameter int ADDR_W = 9,
  parameter int AREA_N = 3
) (
  input  logic [PH_W-1:0]          phase,
  input  logic [AREA_N*ADDR_W-1:0] word_addr,
  output logic [LANES*2-1:0]       lane_sel,
  output logic [NRAM*ADDR_W-1:0]   ram_addr_a,
  output logic [NRAM*ADDR_W-1:0]   ram_addr_b
);
  import swag_pkg::*;

  // Area of lane k: (phase + k) div NRAM.
  function automatic area_e lane_area(input logic [PH_W-1:0] ph, input int k);
    logic [PH_W+1:0] s;
    s = {2'b00, ph} + (PH_W+2)'(k);
    return area_e'(s[PH_W+1:PH_W]);
  endfunction

  // RAMs left of the phase hold the row's first pixel one group later.
  function automatic logic ram_shifted(input int m, input logic [PH_W-1:0] ph);
    return PH_W'(m) < ph;
  endfunction

  logic [ADDR_W-1:0] a0, a1, a2;
  assign a0 = word_addr[0*ADDR_W +: ADDR_W];
  assign a1 = word_addr[1*ADDR_W +: ADDR_W];
  assign a2 = word_addr[2*ADDR_W +: ADDR_W];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_sel[k*2 +: 2] = lane_area(phase, k);
  end

  for (genvar m = 0; m < NRAM; m++) begin : g_ram
    logic shifted;
    assign shifted = ram_shifted(m, phase);
    assign ram_addr_a[m*ADDR_W +: ADDR_W] = shifted ? a1 : a0;
    assign ram_addr_b[m*ADDR_W +: ADDR_W] = shifted ? a2 : a1;
  end
endmodule

// File: rtl/sw_addr_gen.sv
module sw_addr_gen #(
  parameter int BUF_W    = 64,
  parameter int BUF_H    = 64,
  parameter int NRAM     = 8,
  parameter int LANES    = 16,
  parameter int ROWS     = 16,
  parameter int OFS_STEP = 16,
  parameter int VEC_W    = 6,
  parameter int ORG_X    = 24,
  parameter int ORG_Y    = 24,
  localparam int COL_W      = $clog2(BUF_W),
  localparam int ROW_W      = $clog2(BUF_H),
  localparam int PH_W       = $clog2(NRAM),
  localparam int GRP_W      = COL_W - PH_W,
  localparam int ADDR_W     = ROW_W + GRP_W,
  localparam int OFS_W      = $clog2(BUF_W / OFS_STEP),
  localparam int RCNT_W     = $clog2(ROWS),
  localparam int LINE_WORDS = BUF_W / NRAM,
  localparam int AREA_N     = swag_pkg::AREA_N
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic signed [VEC_W-1:0]  vec_x,
  input  logic signed [VEC_W-1:0]  vec_y,
  input  logic [OFS_W-1:0]         win_ofs,
  output logic                     row_valid,
  output logic [RCNT_W-1:0]        row_idx,
  output logic                     row_done,
  output logic [AREA_N*ADDR_W-1:0] word_addr,
  output logic [NRAM*ADDR_W-1:0]   ram_addr_a,
  output logic [NRAM*ADDR_W-1:0]   ram_addr_b,
  output logic [LANES*2-1:0]       lane_sel
);
  logic [COL_W-1:0] phys_x;
  logic [ROW_W-1:0] phys_y;
  logic [PH_W-1:0]  phase;
  logic             launch;
  logic             last_row;

  swag_coord #(
    .VEC_W(VEC_W), .COL_W(COL_W), .ROW_W(ROW_W), .OFS_W(OFS_W),
    .OFS_STEP(OFS_STEP), .ORG_X(ORG_X), .ORG_Y(ORG_Y)
  ) u_coord (
    .vec_x(vec_x), .vec_y(vec_y), .win_ofs(win_ofs),
    .phys_x(phys_x), .phys_y(phys_y)
  );

  swag_row_seq #(
    .ROWS(ROWS), .LINE_WORDS(LINE_WORDS), .COL_W(COL_W), .ROW_W(ROW_W),
    .PH_W(PH_W), .GRP_W(GRP_W), .ADDR_W(ADDR_W), .RCNT_W(RCNT_W),
    .AREA_N(AREA_N)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .phys_x(phys_x), .phys_y(phys_y),
    .row_valid(row_valid), .row_idx(row_idx), .row_done(row_done),
    .word_addr(word_addr), .phase(phase),
    .launch(launch), .last_row(last_row)
  );

  swag_lane_map #(
    .LANES(LANES), .NRAM(NRAM), .PH_W(PH_W), .ADDR_W(ADDR_W), .AREA_N(AREA_N)
  ) u_map (
    .phase(phase), .word_addr(word_addr), .lane_sel(lane_sel),
    .ram_addr_a(ram_addr_a), .ram_addr_b(ram_addr_b)
  );
endmodule

// File: rtl/sw_addr_gen_chk.sv
module sw_addr_gen_chk #(
  parameter int ROWS       = 16,
  parameter int NRAM       = 8,
  parameter int LANES      = 16,
  parameter int ADDR_W     = 9,
  parameter int GRP_W      = 3,
  parameter int RCNT_W     = 4,
  parameter int LINE_WORDS = 8,
  parameter int AREA_N     = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     row_valid,
  input logic [RCNT_W-1:0]        row_idx,
  input logic                     row_done,
  input logic [AREA_N*ADDR_W-1:0] word_addr,
  input logic [NRAM*ADDR_W-1:0]   ram_addr_a,
  input logic [NRAM*ADDR_W-1:0]   ram_addr_b,
  input logic [LANES*2-1:0]       lane_sel,
  input logic                     launch,
  input logic                     last_row
);
  // R2
  burst_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (row_valid && row_idx == '0));

  // R4
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && row_valid && !last_row) |=> (row_valid && row_idx == $past(row_idx) + RCNT_W'(1)));

  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_row |=> (row_done && !row_valid));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |=> !row_done);

  // R7
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && !last_row) |=>
      (word_addr[ADDR_W-1:0] == $past(word_addr[ADDR_W-1:0]) + ADDR_W'(LINE_WORDS)));

  // R8
  lane_first_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid |-> (lane_sel[1:0] == 2'd0 && lane_sel[LANES*2-1 -: 2] != 2'd0));

  // R9
  for (genvar m = 0; m < NRAM; m++) begin : g_port
    port_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_valid |->
        (ram_addr_b[m*ADDR_W+GRP_W +: ADDR_W-GRP_W] == ram_addr_a[m*ADDR_W+GRP_W +: ADDR_W-GRP_W]
         && ram_addr_b[m*ADDR_W +: GRP_W] == ram_addr_a[m*ADDR_W +: GRP_W] + GRP_W'(1)));
  end
endmodule

bind sw_addr_gen sw_addr_gen_chk #(
  .ROWS(ROWS), .NRAM(NRAM), .LANES(LANES), .ADDR_W(ADDR_W), .GRP_W(GRP_W),
  .RCNT_W(RCNT_W), .LINE_WORDS(LINE_WORDS), .AREA_N(AREA_N)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .row_valid(row_valid),
  .row_idx(row_idx), .row_done(row_done), .word_addr(word_addr),
  .ram_addr_a(ram_addr_a), .ram_addr_b(ram_addr_b), .lane_sel(lane_sel),
  .launch(launch), .last_row(last_row)
);

// File: tb/sw_addr_gen_test.sv
`timescale 1ns/1ps
module sw_addr_gen_test;
  localparam int AW = 9;
  localparam int OX = 24;
  localparam int OY = 24;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic signed [5:0] vec_x = '0;
  logic signed [5:0] vec_y = '0;
  logic [1:0]       win_ofs = '0;
  logic             row_valid;
  logic [3:0]       row_idx;
  logic             row_done;
  logic [3*AW-1:0]  word_addr;
  logic [8*AW-1:0]  ram_addr_a;
  logic [8*AW-1:0]  ram_addr_b;
  logic [31:0]      lane_sel;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  sw_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_x(vec_x), .vec_y(vec_y),
    .win_ofs(win_ofs), .row_valid(row_valid), .row_idx(row_idx),
    .row_done(row_done), .word_addr(word_addr), .ram_addr_a(ram_addr_a),
    .ram_addr_b(ram_addr_b), .lane_sel(lane_sel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int wrap64(input int v);
    return ((v % 64) + 64) % 64;
  endfunction

  // One burst; restart_at >= 0 pulses start again during that row.
  task automatic burst(input int vx, input int vy, input int ofs, input int restart_at);
    int px;
    @(negedge clk);
    vec_x = 6'(vx); vec_y = 6'(vy); win_ofs = 2'(ofs); start = 1'b1;
    px = wrap64(OX + vx + 16 * ofs);
    @(negedge clk);
    start = 1'b0;
    // R10: disturb inputs once captured
    vec_x = ~vec_x; vec_y = vec_y + 6'sd7; win_ofs = win_ofs + 2'd1;
    for (int r = 0; r < 16; r++) begin
      int line;
      line = wrap64(OY + vy + r);
      check(row_valid === 1'b1 && row_idx == 4'(r), "R2 row", int'(row_idx), r);
      for (int j = 0; j < 3; j++) begin
        int e;
        e = line * 8 + ((px / 8 + j) % 8);
        check(int'(word_addr[j*AW +: AW]) == e, "R5 R6 word address",
              int'(word_addr[j*AW +: AW]), e);
      end
      for (int k = 0; k < 16; k++) begin
        int col, e, act, es;
        col = (px + k) % 64;
        e = line * 8 + col / 8;
        act = (k < 8) ? int'(ram_addr_a[(col % 8)*AW +: AW])
                      : int'(ram_addr_b[(col % 8)*AW +: AW]);
        check(act == e, "R9 R7 ram port", act, e);
        es = ((px % 8) + k) / 8;
        check(int'(lane_sel[k*2 +: 2]) == es, "R8 lane area", int'(lane_sel[k*2 +: 2]), es);
      end
      if (r == restart_at) begin
        // R4: start during an active row, with different inputs
        start = 1'b1; vec_x = vec_x + 6'sd5; win_ofs = win_ofs + 2'd2;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check(row_done === 1'b1 && row_valid === 1'b0, "R3 done pulse", int'(row_done), 1);
    @(negedge clk);
    check(row_done === 1'b0 && row_valid === 1'b0, "R3 R4 single done, no new burst",
          int'(row_valid), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 200000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(row_valid === 1'b0 && row_done === 1'b0, "R1 reset flags", int'(row_valid), 0);
    check(word_addr == '0 && ram_addr_a == '0, "R1 reset address", int'(word_addr[AW-1:0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 idle: no start, nothing happens
    check(row_valid === 1'b0, "R2 idle", int'(row_valid), 0);

    // R5 R6: all columns, all offsets, top line and bottom-wrapping line
    for (int ofs = 0; ofs < 4; ofs++)
      for (int vx = -32; vx < 32; vx++) begin
        burst(vx, -24, ofs, -1);
        burst(vx, 31, ofs, -1);
      end
    // R5: line never remapped by offset
    for (int vy = -32; vy < 32; vy++) burst(3, vy, 1, -1);
    // R4: start mid-burst and in the last row
    burst(9, 5, 2, 5);
    burst(-17, -3, 3, 15);
    burst(31, 31, 3, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule